// File: doc/BRIEF.md
# 16-bit PWM Timer with Capture

A 16-bit timer/counter with two compare channels, a capture/hold register and five counting modes: free running, clear on compare (TOP taken from compare register A or from the hold register), and two dual-slope PWM modes that count up to TOP and back down. The counter advances only on cycles where the external clock-enable `tick` is high, so an external prescaler sets the count rate. Each channel drives one waveform pin. Four sticky flags report overflow, the two compare matches and captures.

Software reaches the block over an 8-bit register bus. Every 16-bit register is split into a low and a high byte, and one shared temporary byte makes each 16-bit access atomic. A read of a low byte copies the high byte of the same register into the temporary byte, and a later high-byte read returns that copy. A write puts the high byte into the temporary byte, and the low-byte write then commits all 16 bits at once. In the dual-slope modes the compare registers are double-buffered. Any write to the counter suppresses compare matches for the next tick.

Register map (4-bit address, read data appears one cycle after `bus_rd`): 0 control, 1 flags, 2/3 counter low/high, 4/5 compare A low/high, 6/7 compare B low/high, 8/9 hold low/high. Control bits [2:0] select the mode: 0 free running, 1 clear on compare with TOP from compare A, 2 clear on compare with TOP from hold, 3 dual slope with buffer update at TOP, 4 dual slope with buffer update at BOTTOM. Bits [5:4] and [7:6] are the output modes of channels A and B. Flag bits: 0 overflow, 1 compare A, 2 compare B, 3 capture.

Top module: `timer16_pwm`

## Requirements
- R1: After reset the counter, compare, hold, control and flag registers read zero, and both waveform pins and all flag pins are low.
- R2: A read of a low byte (address 2, 4, 6 or 8) loads the high byte of that register into the temporary byte in the same cycle, and a read of the matching high byte returns the temporary byte, even if the register has changed since.
- R3: A write to a high byte only loads the temporary byte. The register changes only when its low byte is written, and it then takes {temporary byte, low data} in one cycle.
- R4: In mode 0 the counter increments by one per tick and wraps from 0xFFFF to 0. The wrap sets flag bit 0 at that tick.
- R5: A counter write suppresses compare matches on both channels for the first tick after it. A compare match at a tick sets flag bit 1 (A) or bit 2 (B) at that tick.
- R6: In modes 1 and 2 the counter clears to 0 on the tick where it equals TOP (compare A in mode 1, hold in mode 2), instead of incrementing.
- R7: In modes 0 and 1 a rising edge on `cap_in` copies the counter into the hold register and sets flag bit 3. In modes 2, 3 and 4 such an edge changes neither the hold register nor flag bit 3.
- R8: A write to the hold register takes effect at once, including when it is the TOP of mode 2.
- R9: Writing the flag register clears exactly the bits written as one. Bits written as zero keep their value.
- R10: In modes 0, 1 and 2 a compare write takes effect for matching at once. In mode 3 it goes to a buffer whose value becomes active on the tick where the counter is at TOP while counting up.
- R11: In mode 4 the compare buffer becomes active on the tick where the counter is at 0 while counting down, and not at TOP.
- R12: Output mode 00 holds the pin low. Mode 01 toggles the pin on a match. Modes 10 and 11 clear and set it (in dual slope: 10 clears on an up-count match and sets on a down-count match, and 11 does the reverse).
- R13: In modes 3 and 4 the counter turns down at TOP and turns up at 0. The tick at 0 while counting down sets flag bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from an external prescaler |
| cap_in | input | 1 | Synchronised capture input, rising edge active |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the read strobe |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| flag_ovf | output | 1 | Overflow flag |
| flag_cmp_a | output | 1 | Compare A match flag |
| flag_cmp_b | output | 1 | Compare B match flag |
| flag_cap | output | 1 | Capture flag |

## Verification
Counter, waveform pins and flags change at the clock edge that samples `tick` high, so the bench drives one tick per cycle and checks pins one time unit after that edge. Read data is due one cycle after the read strobe, so the driver queues each expected byte and the monitor compares it on the falling edge after the returning edge. Captures are due at the edge that first samples `cap_in` high. Dual-slope cases are counted tick by tick against the TOP/BOTTOM turning points, so that a buffer update at the wrong point moves a waveform edge by at least one tick.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam logic [2:0] MD_FREE   = 3'd0;
  localparam logic [2:0] MD_CLR_A  = 3'd1;
  localparam logic [2:0] MD_CLR_H  = 3'd2;
  localparam logic [2:0] MD_DUAL_T = 3'd3;
  localparam logic [2:0] MD_DUAL_B = 3'd4;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_FLAG = 4'd1;
  localparam logic [3:0] A_CNT  = 4'd2;
  localparam logic [3:0] A_CMPA = 4'd4;
  localparam logic [3:0] A_CMPB = 4'd6;
  localparam logic [3:0] A_HOLD = 4'd8;

  localparam int NCH = 2;

  function automatic logic is_dual(input logic [2:0] m);
    return (m == MD_DUAL_T) || (m == MD_DUAL_B);
  endfunction

  function automatic logic is_clr(input logic [2:0] m);
    return (m == MD_CLR_A) || (m == MD_CLR_H);
  endfunction

  function automatic logic hold_is_top(input logic [2:0] m);
    return (m == MD_CLR_H) || is_dual(m);
  endfunction
endpackage

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         cmp_en,
  output logic         ev_top,
  output logic         ev_bot,
  output logic         ovf_ev
);
  logic blk, dual, clr, hit_top, hit_zero, hit_max, step;

  assign dual     = is_dual(mode);
  assign clr      = is_clr(mode);
  assign hit_top  = (cnt == top);
  assign hit_zero = (cnt == '0);
  assign hit_max  = (cnt == '1);
  assign step     = tick && !ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      down <= 1'b0;
      blk  <= 1'b0;
    end else if (ld) begin
      cnt <= ld_val;
      blk <= 1'b1;
    end else if (tick) begin
      blk <= 1'b0;
      if (!dual) begin
        down <= 1'b0;
        cnt  <= (clr && hit_top) ? '0 : cnt + 1'b1;
      end else if (!down) begin
        if (hit_top && !hit_zero) begin
          down <= 1'b1;
          cnt  <= cnt - 1'b1;
        end else if (!hit_top) begin
          cnt <= cnt + 1'b1;
        end
      end else if (hit_zero) begin
        down <= 1'b0;
        if (!hit_top) cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cmp_en = step && !blk;
  assign ev_top = step && dual && !down && hit_top;
  assign ev_bot = step && dual && down && hit_zero;
  assign ovf_ev = dual ? ev_bot : (step && hit_max && !(clr && hit_top));

  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MD_FREE && hit_max) |=> (cnt == '0)); // R4
  AST_CLEAR_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (step && clr && hit_top) |=> (cnt == '0)); // R6
  AST_BOTTOM_TURN: assert property (@(posedge clk) disable iff (rst)
    ev_bot |=> !down); // R13
endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_en,
  input  logic         dual,
  input  logic         upd_at_bot,
  input  logic         ev_top,
  input  logic         ev_bot,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic [1:0]   om,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         match,
  output logic         out
);
  logic upd, wave, wave_n;

  assign upd   = dual && (upd_at_bot ? ev_bot : ev_top);
  assign match = cmp_en && (cnt == active);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (wr) shadow <= wr_val;
      if (wr && !dual) active <= wr_val;
      else if (upd)    active <= shadow;
    end
  end

  always_comb begin
    wave_n = wave;
    if (match) begin
      case (om)
        2'b01:   wave_n = ~wave;
        2'b10:   wave_n = dual ? down : 1'b0;
        2'b11:   wave_n = dual ? ~down : 1'b1;
        default: wave_n = wave;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
      out  <= 1'b0;
    end else begin
      wave <= wave_n;
      out  <= (om == 2'b00) ? 1'b0 : wave_n;
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    (om == 2'b00) |=> !out); // R12
  AST_PWM_BUFFERED: assert property (@(posedge clk) disable iff (rst)
    (dual && wr && !upd) |=> $stable(active)); // R10
endmodule

// File: rtl/timer16_pwm.sv
module timer16_pwm
  import tmr16_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cap_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wave_a,
  output logic          wave_b,
  output logic          flag_ovf,
  output logic          flag_cmp_a,
  output logic          flag_cmp_b,
  output logic          flag_cap
);
  localparam int W = 2 * DW;

  logic [DW-1:0]  ctrl, temp;
  logic [W-1:0]   full, cnt, hold, top;
  logic [2:0]     mode;
  logic [3:0]     flags, flag_set, flag_clr;
  logic           cnt_ld, cap_q, cap_ev, hi_sel;
  logic           down, cmp_en, ev_top, ev_bot, ovf_ev;
  logic [W-1:0]   ch_shd [NCH];
  logic [W-1:0]   ch_act [NCH];
  logic [NCH-1:0] ch_match, ch_out;

  assign mode   = ctrl[2:0];
  assign full   = {temp, bus_wdata};
  assign cnt_ld = bus_wr && (bus_addr == A_CNT);
  assign top    = (mode == MD_CLR_A) ? ch_act[0] : hold;
  assign hi_sel = bus_addr[0] && (bus_addr >= A_CNT) && (bus_addr <= A_HOLD + 4'd1);

  tmr16_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .ld(cnt_ld), .ld_val(full),
    .top(top), .cnt(cnt), .down(down), .cmp_en(cmp_en), .ev_top(ev_top),
    .ev_bot(ev_bot), .ovf_ev(ovf_ev)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr16_chan #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .cmp_en(cmp_en), .dual(is_dual(mode)),
      .upd_at_bot(mode == MD_DUAL_B), .ev_top(ev_top), .ev_bot(ev_bot),
      .wr(bus_wr && (bus_addr == A_CMPA + 4'(2 * i))), .wr_val(full),
      .cnt(cnt), .down(down), .om(ctrl[4 + 2 * i +: 2]),
      .shadow(ch_shd[i]), .active(ch_act[i]), .match(ch_match[i]), .out(ch_out[i])
    );
  end

  assign wave_a = ch_out[0];
  assign wave_b = ch_out[1];

  // shared high-byte latch
  always_ff @(posedge clk) begin
    if (rst) begin
      temp <= '0;
    end else if (bus_wr && hi_sel) begin
      temp <= bus_wdata;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CNT:   temp <= cnt[W-1:DW];
        A_CMPA:  temp <= ch_shd[0][W-1:DW];
        A_CMPB:  temp <= ch_shd[1][W-1:DW];
        A_HOLD:  temp <= hold[W-1:DW];
        default: temp <= temp;
      endcase
    end
  end

  // control and hold/capture
  assign cap_ev = cap_in && !cap_q && !hold_is_top(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      hold  <= '0;
      cap_q <= 1'b0;
    end else begin
      cap_q <= cap_in;
      if (bus_wr && bus_addr == A_CTRL) ctrl <= bus_wdata;
      if (bus_wr && bus_addr == A_HOLD) hold <= full;
      else if (cap_ev)                  hold <= cnt;
    end
  end

  // sticky flags, write one to clear
  assign flag_set = {cap_ev, ch_match[1], ch_match[0], ovf_ev};
  assign flag_clr = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[3:0] : 4'd0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~flag_clr) | flag_set;
  end

  assign flag_ovf   = flags[0];
  assign flag_cmp_a = flags[1];
  assign flag_cmp_b = flags[2];
  assign flag_cap   = flags[3];

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL: bus_rdata <= ctrl;
        A_FLAG: bus_rdata <= {{(DW-4){1'b0}}, flags};
        A_CNT:  bus_rdata <= cnt[DW-1:0];
        A_CMPA: bus_rdata <= ch_shd[0][DW-1:0];
        A_CMPB: bus_rdata <= ch_shd[1][DW-1:0];
        A_HOLD: bus_rdata <= hold[DW-1:0];
        A_CNT + 4'd1, A_CMPA + 4'd1, A_CMPB + 4'd1, A_HOLD + 4'd1: bus_rdata <= temp;
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_W1C_OVF: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_FLAG && bus_wdata[0] && !ovf_ev) |=> !flag_ovf); // R9
  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (cnt_ld ##1 (tick && !bus_wr)) |=> !$rose(flag_cmp_a)); // R5
  AST_CAP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (hold_is_top(mode) && !(bus_wr && bus_addr == A_HOLD)) |=> $stable(hold)); // R7
endmodule

// File: tb/tb_timer16_pwm.sv
module tb_timer16_pwm;
  localparam int DW = 8;
  localparam logic [3:0] RC = 4'd0, RF = 4'd1, RN = 4'd2, RA = 4'd4, RB = 4'd6, RH = 4'd8;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, cap_in = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic wave_a, wave_b, flag_ovf, flag_cmp_a, flag_cmp_b, flag_cap;

  timer16_pwm #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .tick(tick), .cap_in(cap_in), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wave_a(wave_a), .wave_b(wave_b),
    .flag_ovf(flag_ovf), .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b),
    .flag_cap(flag_cap)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sbq[$];
  bit rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: read data is due one cycle after the strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      n_chk++;
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: unexpected read data act=%h exp=none", bus_rdata);
      end else begin
        e = sbq.pop_front();
        if (bus_rdata !== e.val) begin
          n_bad++;
          $display("FAIL %s: act=%h exp=%h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(a + 4'd1, v[15:8]);
    wr(a, v[7:0]);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] v, input string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    sbq.push_back(e);
    bus_rd = 1'b1; bus_addr = a;
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] a, input logic [15:0] v, input string tag);
    rd(a, v[7:0], tag);
    rd(a + 4'd1, v[15:8], tag);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
    end
    tick = 1'b0;
  endtask

  task automatic pin(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    cyc(); cyc();
    if (sbq.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: act=%0d pending reads exp=0", sbq.size());
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();

    // R1 reset state
    pin(wave_a, 1'b0, "R1 wave_a");
    pin(wave_b, 1'b0, "R1 wave_b");
    pin(flag_ovf | flag_cmp_a | flag_cmp_b | flag_cap, 1'b0, "R1 flags pins");
    rd16(RN, 16'h0000, "R1 counter");
    rd(RF, 8'h00, "R1 flags");
    rd16(RB, 16'h0000, "R1 compare B");
    rd(RC, 8'h00, "R1 control");

    // R3 high write alone does not commit; R2 latch
    wr16(RN, 16'h01FF);
    wr(RN + 4'd1, 8'hAB);
    rd(RN, 8'hFF, "R3 low after lone high write");
    rd(RN + 4'd1, 8'h01, "R3 high after lone high write");
    rd(RN, 8'hFF, "R2 low read");
    step(1);
    rd(RN + 4'd1, 8'h01, "R2 latched high byte");
    rd16(RN, 16'h0200, "R2 fresh 16-bit read");

    // R4 wrap and overflow
    wr16(RN, 16'hFFFE);
    wr(RF, 8'h0F);
    step(2);
    pin(flag_ovf, 1'b1, "R4 overflow flag");
    rd(RF, 8'h01, "R4 flags after wrap");
    rd16(RN, 16'h0000, "R4 counter wrapped");

    // R9 selective clear (compare A and B both 0 match now)
    step(1);
    rd(RF, 8'h07, "R5 matches at zero");
    wr(RF, 8'h01);
    rd(RF, 8'h06, "R9 clear only bit 0");
    wr(RF, 8'h06);
    rd(RF, 8'h00, "R9 clear remaining");

    // R5 blocking, R10 immediate compare in mode 0
    wr16(RA, 16'h0010);
    wr16(RN, 16'h0010);
    step(1);
    rd(RF, 8'h00, "R5 match blocked after counter write");
    wr16(RN, 16'h000F);
    step(2);
    rd(RF, 8'h02, "R10 immediate compare match");
    wr(RF, 8'h0F);

    // R6 clear on compare A, R12 toggle
    wr16(RA, 16'h0003);
    wr(RC, 8'h11);
    wr16(RN, 16'h0000);
    step(3);
    pin(wave_a, 1'b0, "R6 no toggle before TOP");
    step(1);
    pin(wave_a, 1'b1, "R12 toggle at TOP");
    rd16(RN, 16'h0000, "R6 cleared at TOP");
    step(4);
    pin(wave_a, 1'b0, "R6 period of four ticks");
    step(4);
    pin(wave_a, 1'b1, "R6 third toggle");

    // R12 disconnect
    wr(RC, 8'h01);
    cyc();
    pin(wave_a, 1'b0, "R12 mode 00 holds pin low");

    // R7 capture in mode 1
    wr16(RN, 16'h0123);
    wr(RF, 8'h0F);
    cap_in = 1'b1;
    cyc();
    pin(flag_cap, 1'b1, "R7 capture flag");
    cap_in = 1'b0;
    rd16(RH, 16'h0123, "R7 captured count");
    rd16(RN, 16'h0123, "R7 counter untouched");

    // R8 hold as TOP, R7 capture ignored
    wr16(RH, 16'h0002);
    wr(RC, 8'h02);
    wr16(RN, 16'h0000);
    step(3);
    rd16(RN, 16'h0000, "R8 hold TOP clears");
    wr(RF, 8'h0F);
    cap_in = 1'b1;
    cyc();
    cap_in = 1'b0;
    cyc();
    rd(RF, 8'h00, "R7 no capture flag in mode 2");
    rd16(RH, 16'h0002, "R7 hold unchanged in mode 2");

    // R10 update at TOP, R12 dual slope, R13 bottom overflow
    wr16(RH, 16'h0004);
    wr(RC, 8'h83);
    wr16(RB, 16'h0002);
    rd16(RB, 16'h0002, "R10 buffer readback");
    wr16(RN, 16'h0000);
    wr(RF, 8'h0F);
    step(6);
    pin(wave_b, 1'b0, "R10 old compare until TOP");
    step(1);
    pin(wave_b, 1'b1, "R12 set on down match");
    step(1);
    pin(flag_ovf, 1'b0, "R13 no overflow before bottom");
    step(1);
    pin(flag_ovf, 1'b1, "R13 overflow at bottom");
    step(2);
    pin(wave_b, 1'b0, "R12 clear on up match");
    rd16(RN, 16'h0003, "R13 counting up again");

    // R11 update at BOTTOM
    wr(RC, 8'h84);
    wr16(RB, 16'h0003);
    step(3);
    pin(wave_b, 1'b0, "R11 no update at TOP");
    step(1);
    pin(wave_b, 1'b1, "R11 old compare on way down");
    step(4);
    pin(wave_b, 1'b1, "R11 new compare after bottom");
    step(1);
    pin(wave_b, 1'b0, "R11 new compare matches");

    done = 1'b1;
    wrap_up();
    $finish;
  end
endmodule